// File: doc/BRIEF.md
# Condition Flag Stack Shifter

This block holds a processor's 32-bit condition and status word. The word also acts as a small stack of flag sets. The live flags sit in the lowest 10-bit level. Older flag sets sit in the levels above it. On exception entry the word is pushed: every level moves up by one and the live level is cleared. On exception return the word is popped: every level moves back down. The two most significant bits are a fixed field that neither shift alters.

Besides the shifts, the block accepts four other commands:
- a masked set of flags;
- a masked clear of flags;
- a direct load of the whole word;
- loads of the active and user stack pointers.

The block keeps three stack pointers: the active one, a saved kernel copy and a user copy. When a pop or a set-flags command moves the core into user mode, the active pointer is saved into the kernel copy and then reloaded from the user copy. Instruction decode and exception vectoring happen outside the block. Only one status command takes effect per cycle, chosen by a fixed priority.

Top module: `flag_stack_shifter`

## Requirements
- R1: After reset the status word, the active stack pointer, the kernel copy and the user copy all read zero.
- R2: A direct write replaces the whole status word with `wr_data` on the next cycle and never moves any stack pointer.
- R3: A push keeps bits [31:30], moves bits [19:0] to [29:10] and clears bits [9:0].
- R4: A pop keeps bits [31:30], moves bits [27:10] to [17:0] and clears bits [29:18].
- R5: When the word produced by a pop has the user-mode bit (bit 6) set, the kernel copy takes the old active pointer and the active pointer takes the user copy, in the same cycle.
- R6: A set-flags command ORs `flag_mask` into the word. It performs the R5 pointer swap only if bit 6 was clear before the command and bit 6 of the mask is one.
- R7: A clear-flags command ANDs the word with the inverted mask and never moves any stack pointer.
- R8: When several status commands arrive in one cycle, exactly one takes effect, in the priority order write, push, pop, set, clear.
- R9: Neither a push nor a pop changes bits [31:30].
- R10: `sp_ld_en` loads the active pointer and `usp_ld_en` loads the user copy. A swap in the same cycle takes precedence over the active-pointer load. The kernel copy changes only on a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Direct load of the status word |
| wr_data | input | 32 | Value for the direct load |
| push_en | input | 1 | Push the flag levels up (exception entry) |
| pop_en | input | 1 | Pop the flag levels down (exception return) |
| set_en | input | 1 | OR the mask into the status word |
| clr_en | input | 1 | Clear the masked bits of the status word |
| flag_mask | input | 32 | Mask for the set and clear commands |
| sp_ld_en | input | 1 | Load the active stack pointer |
| sp_ld_val | input | 32 | Value for the active stack pointer load |
| usp_ld_en | input | 1 | Load the user stack pointer copy |
| usp_ld_val | input | 32 | Value for the user copy load |
| status_o | output | 32 | Current status word |
| sp_o | output | 32 | Active stack pointer |
| ksp_o | output | 32 | Kernel stack pointer copy |
| usp_o | output | 32 | User stack pointer copy |

## Verification
The assertions assume that only the highest-priority enable acts in a cycle. Each property therefore guards its antecedent with the absence of every stronger command, and the stack-pointer properties also exclude a pointer load in the same cycle.

The stimulus drives every combination of the enables, including all five at once, so the guards are exercised as well as the single-command cases. Random words put the user bit, set or clear, in every level, so pops that swap and pops that do not both occur. Set commands run with the user bit both clear and already set, so the swap condition is taken from both sides.

// File: rtl/flag_stack_pkg.sv
package flag_stack_pkg;

   // Status command selected for the current cycle
   typedef enum logic [2:0] {
      FS_OP_IDLE  = 3'd0,
      FS_OP_WRITE = 3'd1,
      FS_OP_PUSH  = 3'd2,
      FS_OP_POP   = 3'd3,
      FS_OP_SET   = 3'd4,
      FS_OP_CLEAR = 3'd5
   } fs_op_e;

   // Flag positions inside the live (lowest) level
   localparam int unsigned FLG_CARRY    = 0;
   localparam int unsigned FLG_OVERFLOW = 1;
   localparam int unsigned FLG_ZERO     = 2;
   localparam int unsigned FLG_NEG      = 3;
   localparam int unsigned FLG_EXTEND   = 4;
   localparam int unsigned FLG_IRQ      = 5;
   localparam int unsigned FLG_USER     = 6;
   localparam int unsigned FLG_PREFIX   = 7;
   localparam int unsigned FLG_RESTART  = 8;

endpackage

// File: rtl/fs_cmd_pick.sv
module fs_cmd_pick
   import flag_stack_pkg::*;
(
   input  logic   wr_en,
   input  logic   push_en,
   input  logic   pop_en,
   input  logic   set_en,
   input  logic   clr_en,
   output fs_op_e op
);

   // Fixed priority: write > push > pop > set > clear
   always_comb begin
      if (wr_en)        op = FS_OP_WRITE;
      else if (push_en) op = FS_OP_PUSH;
      else if (pop_en)  op = FS_OP_POP;
      else if (set_en)  op = FS_OP_SET;
      else if (clr_en)  op = FS_OP_CLEAR;
      else              op = FS_OP_IDLE;
   end

   always_comb begin
      AST_IDLE_ONLY_WHEN_QUIET: assert ((op != FS_OP_IDLE) == (wr_en | push_en | pop_en | set_en | clr_en)); // R8
   end

endmodule

// File: rtl/fs_level_shift.sv
module fs_level_shift #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEVEL_W   = 10,
   parameter int unsigned KEEP_W    = 2,
   parameter int unsigned POP_GAP_W = 2
) (
   input  logic [DATA_W-1:0] cur,
   output logic [DATA_W-1:0] pushed,
   output logic [DATA_W-1:0] popped
);

   localparam int unsigned STACK_TOP = DATA_W - KEEP_W;             // first fixed bit
   localparam int unsigned POP_SRC_H = STACK_TOP - POP_GAP_W - 1;   // highest bit that pops down
   localparam int unsigned POP_DST_H = POP_SRC_H - LEVEL_W;         // its landing position

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b >= STACK_TOP) begin : g_fixed
         assign pushed[b] = cur[b];
         assign popped[b] = cur[b];
      end else begin : g_stack
         if (b >= LEVEL_W) begin : g_push_move
            assign pushed[b] = cur[b - LEVEL_W];
         end else begin : g_push_zero
            assign pushed[b] = 1'b0;
         end
         if (b <= POP_DST_H) begin : g_pop_move
            assign popped[b] = cur[b + LEVEL_W];
         end else begin : g_pop_zero
            assign popped[b] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/fs_sp_bank.sv
module fs_sp_bank #(
   parameter int unsigned SP_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            swap,
   input  logic            sp_ld_en,
   input  logic [SP_W-1:0] sp_ld_val,
   input  logic            usp_ld_en,
   input  logic [SP_W-1:0] usp_ld_val,
   output logic [SP_W-1:0] sp,
   output logic [SP_W-1:0] ksp,
   output logic [SP_W-1:0] usp
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp  <= '0;
         ksp <= '0;
         usp <= '0;
      end else begin
         if (swap) begin
            ksp <= sp;
            sp  <= usp;
         end else if (sp_ld_en) begin
            sp <= sp_ld_val;
         end
         if (usp_ld_en) usp <= usp_ld_val;
      end
   end

   AST_SWAP_SAVES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> ksp == $past(sp)); // R5
   AST_SWAP_LOADS_USER: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> sp == $past(usp)); // R5
   AST_KERNEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> $stable(ksp)); // R10
   AST_USER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      usp_ld_en |=> usp == $past(usp_ld_val)); // R10

endmodule

// File: rtl/flag_stack_shifter.sv
module flag_stack_shifter
   import flag_stack_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEVEL_W   = 10,
   parameter int unsigned KEEP_W    = 2,
   parameter int unsigned POP_GAP_W = 2,
   parameter int unsigned SP_W      = 32,
   parameter int unsigned USER_BIT  = FLG_USER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              push_en,
   input  logic              pop_en,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] flag_mask,
   input  logic              sp_ld_en,
   input  logic [SP_W-1:0]   sp_ld_val,
   input  logic              usp_ld_en,
   input  logic [SP_W-1:0]   usp_ld_val,
   output logic [DATA_W-1:0] status_o,
   output logic [SP_W-1:0]   sp_o,
   output logic [SP_W-1:0]   ksp_o,
   output logic [SP_W-1:0]   usp_o
);

   localparam int unsigned STACK_TOP = DATA_W - KEEP_W;
   localparam int unsigned POP_CLR_L = STACK_TOP - LEVEL_W - POP_GAP_W;

   initial begin
      if (KEEP_W + LEVEL_W + POP_GAP_W >= DATA_W)
         $error("flag_stack_shifter: fixed field, gap and one level do not fit the word");
      if (USER_BIT >= LEVEL_W)
         $error("flag_stack_shifter: user bit must lie inside the live level");
   end

   fs_op_e            op;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] status_d;
   logic [DATA_W-1:0] pushed;
   logic [DATA_W-1:0] popped;
   logic              swap;

   fs_cmd_pick u_pick (
      .wr_en   (wr_en),
      .push_en (push_en),
      .pop_en  (pop_en),
      .set_en  (set_en),
      .clr_en  (clr_en),
      .op      (op)
   );

   fs_level_shift #(
      .DATA_W    (DATA_W),
      .LEVEL_W   (LEVEL_W),
      .KEEP_W    (KEEP_W),
      .POP_GAP_W (POP_GAP_W)
   ) u_shift (
      .cur    (status_q),
      .pushed (pushed),
      .popped (popped)
   );

   always_comb begin
      status_d = status_q;
      swap     = 1'b0;
      case (op)
         FS_OP_WRITE: status_d = wr_data;
         FS_OP_PUSH:  status_d = pushed;
         FS_OP_POP: begin
            status_d = popped;
            swap     = popped[USER_BIT];
         end
         FS_OP_SET: begin
            status_d = status_q | flag_mask;
            swap     = !status_q[USER_BIT] && flag_mask[USER_BIT];
         end
         FS_OP_CLEAR: status_d = status_q & ~flag_mask;
         default:     status_d = status_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

   fs_sp_bank #(.SP_W(SP_W)) u_sp (
      .clk        (clk),
      .rst_n      (rst_n),
      .swap       (swap),
      .sp_ld_en   (sp_ld_en),
      .sp_ld_val  (sp_ld_val),
      .usp_ld_en  (usp_ld_en),
      .usp_ld_val (usp_ld_val),
      .sp         (sp_o),
      .ksp        (ksp_o),
      .usp        (usp_o)
   );

   assign status_o = status_q;

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> status_o == $past(wr_data)); // R2
   AST_PUSH_CLEARS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && !wr_en) |=> status_o[LEVEL_W-1:0] == '0); // R3
   AST_POP_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && !push_en && !wr_en) |=> status_o[STACK_TOP-1:POP_CLR_L] == '0); // R4
   AST_SHIFT_KEEPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      ((push_en || pop_en) && !wr_en) |=> status_o[DATA_W-1:STACK_TOP] == $past(status_o[DATA_W-1:STACK_TOP])); // R9
   AST_SET_HOLDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !wr_en && !push_en && !pop_en) |=> (status_o & $past(flag_mask)) == $past(flag_mask)); // R6
   AST_CLEAR_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en && !pop_en && !push_en && !wr_en && !sp_ld_en) |=> $stable(sp_o) && $stable(ksp_o)); // R7
   AST_WRITE_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sp_ld_en) |=> $stable(sp_o) && $stable(ksp_o)); // R2

endmodule

// File: tb/flag_stack_shifter_bench.sv
module flag_stack_shifter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, push_en = 1'b0, pop_en = 1'b0, set_en = 1'b0, clr_en = 1'b0;
   logic [31:0] wr_data = '0, flag_mask = '0;
   logic        sp_ld_en = 1'b0, usp_ld_en = 1'b0;
   logic [31:0] sp_ld_val = '0, usp_ld_val = '0;
   logic [31:0] status_o, sp_o, ksp_o, usp_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   // Reference state
   logic [31:0] m_st = '0, m_sp = '0, m_ksp = '0, m_usp = '0;

   always #5 clk = ~clk;

   flag_stack_shifter u_flag_stack_shifter (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_data),
      .push_en(push_en), .pop_en(pop_en), .set_en(set_en), .clr_en(clr_en),
      .flag_mask(flag_mask),
      .sp_ld_en(sp_ld_en), .sp_ld_val(sp_ld_val),
      .usp_ld_en(usp_ld_en), .usp_ld_val(usp_ld_val),
      .status_o(status_o), .sp_o(sp_o), .ksp_o(ksp_o), .usp_o(usp_o)
   );

   function automatic logic [31:0] f_push(logic [31:0] s);
      return (s & 32'hC000_0000) | ((s & 32'h000F_FFFF) << 10);
   endfunction

   function automatic logic [31:0] f_pop(logic [31:0] s);
      return (s & 32'hC000_0000) | ((s & 32'h0FFF_FFFF) >> 10);
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk(tag, "status", status_o, m_st);
      chk(tag, "sp", sp_o, m_sp);
      chk(tag, "ksp", ksp_o, m_ksp);
      chk(tag, "usp", usp_o, m_usp);
   endtask

   // Called at a falling edge: drive, update the reference, cross one rising edge.
   task automatic step(bit w, bit pu, bit po, bit se, bit cl,
                       logic [31:0] d, logic [31:0] m,
                       bit sl, logic [31:0] sv, bit ul, logic [31:0] uv);
      logic [31:0] ns;
      bit sw;
      wr_en = w; push_en = pu; pop_en = po; set_en = se; clr_en = cl;
      wr_data = d; flag_mask = m;
      sp_ld_en = sl; sp_ld_val = sv; usp_ld_en = ul; usp_ld_val = uv;
      ns = m_st; sw = 0;
      if (w) ns = d;
      else if (pu) ns = f_push(m_st);
      else if (po) begin ns = f_pop(m_st); sw = ns[6]; end
      else if (se) begin ns = m_st | m; sw = !m_st[6] && m[6]; end
      else if (cl) ns = m_st & ~m;
      if (sw) begin m_ksp = m_sp; m_sp = m_usp; end
      else if (sl) m_sp = sv;
      if (ul) m_usp = uv;
      m_st = ns;
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; push_en = 0; pop_en = 0; set_en = 0; clr_en = 0;
      sp_ld_en = 0; usp_ld_en = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk_all("R1");

      // R10: pointer loads
      step(0,0,0,0,0, '0, '0, 1, 32'h2000_0800, 1, 32'h1000_0400);
      chk_all("R10");
      // R2: direct write, user bit set but no swap
      step(1,0,0,0,0, 32'hC000_0155, '0, 0, '0, 0, '0);
      chk_all("R2");
      // R3/R9: push twice
      step(0,1,0,0,0, '0, '0, 0, '0, 0, '0);
      chk_all("R3");
      step(0,1,0,0,0, '0, '0, 0, '0, 0, '0);
      chk_all("R9");
      // R4/R5: pop brings user bit back to the live level and swaps
      step(0,0,1,0,0, '0, '0, 0, '0, 0, '0);
      chk_all("R4");
      step(0,0,1,0,0, '0, '0, 0, '0, 0, '0);
      chk_all("R5");
      // R7: clear user bit, no swap
      step(0,0,0,0,1, '0, 32'h0000_0040, 0, '0, 0, '0);
      chk_all("R7");
      // R6: set user with it clear -> swap; repeat with it set -> no swap
      step(0,0,0,0,0, '0, '0, 0, '0, 1, 32'h3333_0000);
      step(0,0,0,1,0, '0, 32'h0000_0041, 0, '0, 0, '0);
      chk_all("R6");
      step(0,0,0,0,0, '0, '0, 1, 32'h4444_0000, 1, 32'h5555_0000);
      step(0,0,0,1,0, '0, 32'h0000_0048, 0, '0, 0, '0);
      chk_all("R6");
      // R8: priority combinations
      step(1,1,1,1,1, 32'h8000_0002, 32'hFFFF_FFFF, 0, '0, 0, '0);
      chk_all("R8");
      step(0,1,1,1,1, '0, 32'hFFFF_FFFF, 0, '0, 0, '0);
      chk_all("R8");
      step(0,0,1,1,1, '0, 32'h0000_0040, 0, '0, 0, '0);
      chk_all("R8");
      step(0,0,0,1,1, '0, 32'h0000_0040, 0, '0, 0, '0);
      chk_all("R8");
      // R10: swap beats an active-pointer load in the same cycle
      step(1,0,0,0,0, 32'h0000_0000, '0, 1, 32'h6666_0000, 1, 32'h7777_0000);
      step(0,0,0,1,0, '0, 32'h0000_0040, 1, 32'h8888_0000, 0, '0);
      chk_all("R10");

      // Sweep over all enable combinations with random data
      for (int i = 0; i < 3000; i++) begin
         logic [4:0] en;
         logic [31:0] d, m;
         string tag;
         en = 5'(i % 32);
         d = $urandom;
         m = $urandom;
         if ((i & 3) == 0) m = m | 32'h0000_0040;
         if ((i & 7) == 1) d = d | 32'h0004_0040;
         if ($countones(en) > 1) tag = "R8";
         else if (en[4]) tag = "R2";
         else if (en[3]) tag = "R3";
         else if (en[2]) tag = "R4";
         else if (en[1]) tag = "R6";
         else if (en[0]) tag = "R7";
         else tag = "R10";
         step(en[4], en[3], en[2], en[1], en[0], d, m,
              (i % 5) == 0, $urandom, (i % 7) == 0, $urandom);
         chk_all(tag);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule